// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel Sequencer

This block is the control sequencer of one DMA channel. When the channel is triggered it either hands a single transfer, described by its configuration inputs, straight to the data-moving engine, or it walks a linked list of descriptors held in memory. Each descriptor is four 32-bit words: a control word, a source address, a destination address and a pointer to the next descriptor. The sequencer reads these words over a simple request/ready read port, launches a transfer with them, waits for the engine to report the transfer finished and then decides what to do next from the two-bit mode field in the low bits of the control word.

The mode field has four codes. Code 1 means one transfer and then the channel is finished. Code 2 means transfer and then follow the next pointer. Codes 0 and 3 both mean stop. Because the mode travels inside each loaded descriptor, software builds a chain of any length by linking descriptors, and it ends the chain either with a code-1 entry or with a stop entry. The channel raises a one-cycle completion flag only when the whole chain has ended. The data movement, channel arbitration and interrupt generation belong to other blocks.

Top module: `dma_chain_ctrl`

## Requirements
- R1: After reset, and while no reset-free trigger has been accepted, `busy`, `rd_req`, `xfer_start` and `chan_done` are all 0.
- R2: A trigger in idle with `cfg_ctrl[1:0]` = 1 produces, one clock later, a one-cycle `xfer_start` with `xfer_ctrl`/`xfer_src`/`xfer_dst` equal to `cfg_ctrl`/`cfg_src`/`cfg_dst`, and no descriptor read is made.
- R3: A trigger in idle with `cfg_ctrl[1:0]` equal to 0 or 3 has no effect: `busy`, `rd_req`, `xfer_start` and `chan_done` stay 0.
- R4: A trigger in idle with `cfg_ctrl[1:0]` = 2 starts a descriptor read at byte address `cfg_next`; the four words control, source, destination and next pointer are read in that order at offsets +0, +4, +8, +12, one word per cycle in which `rd_req` and `rd_rdy` are both 1, and `rd_req` and `rd_addr` hold steady while `rd_rdy` is 0.
- R5: When a loaded descriptor's control word has mode 1 or 2, `xfer_start` pulses the cycle after the last word is accepted, with `xfer_ctrl`, `xfer_src`, `xfer_dst` equal to the descriptor's first three words.
- R6: When `xfer_done` is seen for an entry of mode 2, the next descriptor is read starting at the byte address held in that entry's next-pointer word.
- R7: A loaded descriptor of mode 0 or 3 ends the chain with no transfer; an entry of mode 1 ends the chain after its transfer is done.
- R8: `chan_done` is a one-cycle pulse raised exactly once per chain (or basic transfer), in the cycle in which `busy` returns to 0, and never between entries.
- R9: A trigger that arrives while `busy` is 1 is ignored: it does not restart, extend or re-launch the channel once it has finished.
- R10: `xfer_start` is high for exactly one cycle per launched transfer, and `xfer_done` has effect only while a transfer is outstanding.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig | input | 1 | Channel trigger, sampled only in idle |
| cfg_ctrl | input | DATA_W | Channel control word; bits [1:0] are the mode |
| cfg_src | input | ADDR_W | Source address for a basic transfer |
| cfg_dst | input | ADDR_W | Destination address for a basic transfer |
| cfg_next | input | ADDR_W | Byte address of the first descriptor |
| rd_req | output | 1 | Descriptor word read request |
| rd_addr | output | ADDR_W | Byte address of the requested word |
| rd_rdy | input | 1 | Read data valid, completes one word |
| rd_data | input | DATA_W | Descriptor word read data |
| xfer_start | output | 1 | One-cycle launch of a transfer |
| xfer_ctrl | output | DATA_W | Control word of the launched transfer |
| xfer_src | output | ADDR_W | Source address of the launched transfer |
| xfer_dst | output | ADDR_W | Destination address of the launched transfer |
| xfer_done | input | 1 | Transfer engine reports completion |
| chan_done | output | 1 | One-cycle pulse when the channel finishes |
| busy | output | 1 | Channel is not idle |

## Verification
The hardest situation to reach from the ports is a long chain whose words arrive with irregular wait states while triggers keep arriving mid-chain, because only then do the beat counter, the next-pointer hand-off and the idle-only trigger gate all act together. The bench places randomly sized chains at scattered slots of a modelled memory, ends them randomly with a mode-1 entry or a stop entry of code 0 or 3, withholds read ready on random cycles, delays the done response randomly and pulses the trigger on random busy cycles. The expected list of launched transfers is found by walking the modelled memory independently.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_XFER = 2'd2
  } chan_state_t;

  localparam logic [1:0] MODE_STOP  = 2'd0;
  localparam logic [1:0] MODE_BASIC = 2'd1;
  localparam logic [1:0] MODE_CHAIN = 2'd2;

  // A mode that launches a transfer; 0 and 3 both mean stop
  function automatic logic mode_runs(input logic [1:0] m);
    return (m == MODE_BASIC) || (m == MODE_CHAIN);
  endfunction

endpackage

// File: rtl/dma_desc_fetch.sv
module dma_desc_fetch #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int NWORDS = 4
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           go,
  input  logic [ADDR_W-1:0]              go_base,
  output logic                           rd_req,
  output logic [ADDR_W-1:0]              rd_addr,
  input  logic                           rd_rdy,
  input  logic [DATA_W-1:0]              rd_data,
  output logic [NWORDS-1:0][DATA_W-1:0]  words,
  output logic                           fetch_last
);

  localparam int IW    = (NWORDS > 1) ? $clog2(NWORDS) : 1;
  localparam int BYTES = DATA_W / 8;
  localparam logic [IW-1:0]     LAST_BEAT = IW'(NWORDS - 1);
  localparam logic [ADDR_W-1:0] STEP      = ADDR_W'(BYTES);

  logic [IW-1:0] beat;
  logic          accept;

  assign accept     = rd_req && rd_rdy;
  assign fetch_last = accept && (beat == LAST_BEAT);

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_req  <= 1'b0;
      rd_addr <= '0;
      beat    <= '0;
    end else if (go) begin
      rd_req  <= 1'b1;
      rd_addr <= go_base;
      beat    <= '0;
    end else if (accept) begin
      if (beat == LAST_BEAT) begin
        rd_req <= 1'b0;
        beat   <= '0;
      end else begin
        beat    <= beat + 1'b1;
        rd_addr <= rd_addr + STEP;
      end
    end
  end

  // One capture register per descriptor word
  for (genvar i = 0; i < NWORDS; i++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst)
        words[i] <= '0;
      else if (accept && (beat == IW'(i)))
        words[i] <= rd_data;
    end
  end

endmodule

// File: rtl/dma_chain_fsm.sv
module dma_chain_fsm
  import dma_chain_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              trig,
  input  logic [DATA_W-1:0] cfg_ctrl,
  input  logic [ADDR_W-1:0] cfg_src,
  input  logic [ADDR_W-1:0] cfg_dst,
  input  logic [ADDR_W-1:0] cfg_next,
  input  logic              fetch_last,
  input  logic [DATA_W-1:0] d_ctrl,
  input  logic [ADDR_W-1:0] d_src,
  input  logic [ADDR_W-1:0] d_dst,
  input  logic [ADDR_W-1:0] d_next,
  input  logic              xfer_done,
  output logic              fetch_go,
  output logic [ADDR_W-1:0] fetch_base,
  output logic              xfer_start,
  output logic [DATA_W-1:0] xfer_ctrl,
  output logic [ADDR_W-1:0] xfer_src,
  output logic [ADDR_W-1:0] xfer_dst,
  output logic              chan_done,
  output logic              busy
);

  chan_state_t state;
  logic [1:0]  cur_mode;
  logic [1:0]  cfg_mode;
  logic [1:0]  ld_mode;
  logic        done_ok;

  assign cfg_mode = cfg_ctrl[1:0];
  assign ld_mode  = d_ctrl[1:0];
  assign done_ok  = (state == ST_XFER) && xfer_done && !xfer_start;
  assign busy     = (state != ST_IDLE);

  always_comb begin
    fetch_go   = 1'b0;
    fetch_base = d_next;
    if (state == ST_IDLE) begin
      fetch_base = cfg_next;
      fetch_go   = trig && (cfg_mode == MODE_CHAIN);
    end else if (done_ok && (cur_mode == MODE_CHAIN)) begin
      fetch_go = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      cur_mode   <= MODE_STOP;
      xfer_start <= 1'b0;
      chan_done  <= 1'b0;
      xfer_ctrl  <= '0;
      xfer_src   <= '0;
      xfer_dst   <= '0;
    end else begin
      xfer_start <= 1'b0;
      chan_done  <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (trig && (cfg_mode == MODE_BASIC)) begin
            state      <= ST_XFER;
            cur_mode   <= MODE_BASIC;
            xfer_start <= 1'b1;
            xfer_ctrl  <= cfg_ctrl;
            xfer_src   <= cfg_src;
            xfer_dst   <= cfg_dst;
          end else if (trig && (cfg_mode == MODE_CHAIN)) begin
            state <= ST_LOAD;
          end
        end
        ST_LOAD: begin
          if (fetch_last) begin
            if (mode_runs(ld_mode)) begin
              state      <= ST_XFER;
              cur_mode   <= ld_mode;
              xfer_start <= 1'b1;
              xfer_ctrl  <= d_ctrl;
              xfer_src   <= d_src;
              xfer_dst   <= d_dst;
            end else begin
              state     <= ST_IDLE;
              chan_done <= 1'b1;
            end
          end
        end
        ST_XFER: begin
          if (done_ok) begin
            if (cur_mode == MODE_CHAIN) begin
              state <= ST_LOAD;
            end else begin
              state     <= ST_IDLE;
              chan_done <= 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dma_chain_ctrl.sv
module dma_chain_ctrl #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              trig,
  input  logic [DATA_W-1:0] cfg_ctrl,
  input  logic [ADDR_W-1:0] cfg_src,
  input  logic [ADDR_W-1:0] cfg_dst,
  input  logic [ADDR_W-1:0] cfg_next,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_rdy,
  input  logic [DATA_W-1:0] rd_data,
  output logic              xfer_start,
  output logic [DATA_W-1:0] xfer_ctrl,
  output logic [ADDR_W-1:0] xfer_src,
  output logic [ADDR_W-1:0] xfer_dst,
  input  logic              xfer_done,
  output logic              chan_done,
  output logic              busy
);

  // Word order inside a descriptor: control, source, destination, next
  localparam int DESC_WORDS = 4;
  localparam int W_CTRL = 0;
  localparam int W_SRC  = 1;
  localparam int W_DST  = 2;
  localparam int W_NEXT = 3;

  logic                              fetch_go;
  logic [ADDR_W-1:0]                 fetch_base;
  logic                              fetch_last;
  logic [DESC_WORDS-1:0][DATA_W-1:0] desc;

  dma_desc_fetch #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .NWORDS (DESC_WORDS)
  ) u_fetch (
    .clk        (clk),
    .rst        (rst),
    .go         (fetch_go),
    .go_base    (fetch_base),
    .rd_req     (rd_req),
    .rd_addr    (rd_addr),
    .rd_rdy     (rd_rdy),
    .rd_data    (rd_data),
    .words      (desc),
    .fetch_last (fetch_last)
  );

  dma_chain_fsm #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .trig       (trig),
    .cfg_ctrl   (cfg_ctrl),
    .cfg_src    (cfg_src),
    .cfg_dst    (cfg_dst),
    .cfg_next   (cfg_next),
    .fetch_last (fetch_last),
    .d_ctrl     (desc[W_CTRL]),
    .d_src      (ADDR_W'(desc[W_SRC])),
    .d_dst      (ADDR_W'(desc[W_DST])),
    .d_next     (ADDR_W'(desc[W_NEXT])),
    .xfer_done  (xfer_done),
    .fetch_go   (fetch_go),
    .fetch_base (fetch_base),
    .xfer_start (xfer_start),
    .xfer_ctrl  (xfer_ctrl),
    .xfer_src   (xfer_src),
    .xfer_dst   (xfer_dst),
    .chan_done  (chan_done),
    .busy       (busy)
  );

endmodule

// File: rtl/dma_chain_ctrl_chk.sv
module dma_chain_ctrl_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_req,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              rd_rdy,
  input logic              xfer_start,
  input logic              chan_done,
  input logic              busy
);

  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(DATA_W / 8);

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!rd_req && !xfer_start));

  a_r4_hold_req: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !rd_rdy) |=> (rd_req && $stable(rd_addr)));

  a_r4_addr_step: assert property (@(posedge clk) disable iff (rst)
    (rd_req && rd_rdy) |=> (!rd_req || (rd_addr == $past(rd_addr) + STEP)));

  a_r10_start_pulse: assert property (@(posedge clk) disable iff (rst)
    xfer_start |=> !xfer_start);

  a_r10_no_read_in_launch: assert property (@(posedge clk) disable iff (rst)
    xfer_start |-> !rd_req);

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
    chan_done |=> !chan_done);

  a_r8_done_at_idle: assert property (@(posedge clk) disable iff (rst)
    chan_done |-> (!busy && $past(busy)));

endmodule

bind dma_chain_ctrl dma_chain_ctrl_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .rd_req     (rd_req),
  .rd_addr    (rd_addr),
  .rd_rdy     (rd_rdy),
  .xfer_start (xfer_start),
  .chan_done  (chan_done),
  .busy       (busy)
);

// File: tb/dma_chain_ctrl_bench.sv
`timescale 1ns/1ps
module dma_chain_ctrl_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        trig = 1'b0;
  logic [31:0] cfg_ctrl = '0, cfg_src = '0, cfg_dst = '0, cfg_next = '0;
  logic        rd_req, rd_rdy = 1'b0;
  logic [31:0] rd_addr, rd_data = '0;
  logic        xfer_start, xfer_done = 1'b0;
  logic [31:0] xfer_ctrl, xfer_src, xfer_dst;
  logic        chan_done, busy;

  always #2.5 clk = ~clk;

  dma_chain_ctrl u_dma_chain_ctrl (
    .clk(clk), .rst(rst), .trig(trig),
    .cfg_ctrl(cfg_ctrl), .cfg_src(cfg_src), .cfg_dst(cfg_dst), .cfg_next(cfg_next),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_rdy(rd_rdy), .rd_data(rd_data),
    .xfer_start(xfer_start), .xfer_ctrl(xfer_ctrl), .xfer_src(xfer_src),
    .xfer_dst(xfer_dst), .xfer_done(xfer_done), .chan_done(chan_done), .busy(busy)
  );

  logic [31:0] mem [64];
  logic [31:0] exp_ctrl [16];
  logic [31:0] exp_src  [16];
  logic [31:0] exp_dst  [16];
  int exp_n, n_start, n_done, dly, n_tests, n_fail;
  bit seen_rd, seen_busy, prev_start;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // Expected launches found by walking modelled memory
  function automatic void walk(input logic [31:0] ptr);
    logic [31:0] p = ptr;
    exp_n = 0;
    for (int k = 0; k < 16; k++) begin
      logic [1:0] m = mem[p[7:2]][1:0];
      if (m == 2'd0 || m == 2'd3) break;
      exp_ctrl[exp_n] = mem[p[7:2]];
      exp_src[exp_n]  = mem[p[7:2] + 6'd1];
      exp_dst[exp_n]  = mem[p[7:2] + 6'd2];
      exp_n++;
      if (m == 2'd1) break;
      p = mem[p[7:2] + 6'd3];
    end
  endfunction

  // Builds a chain of len running entries; end_basic selects a mode-1 tail
  function automatic logic [31:0] build(input int len, input bit end_basic);
    int s = $urandom_range(0, 15);
    int total = end_basic ? len : len + 1;
    for (int j = 0; j < total; j++) begin
      int slot = (s + 5 * j) % 16;
      int nxt  = (s + 5 * (j + 1)) % 16;
      logic [1:0] m;
      if (j < len - 1 || (j == len - 1 && !end_basic)) m = 2'd2;
      else if (j == len - 1) m = 2'd1;
      else m = ($urandom_range(0, 1) != 0) ? 2'd3 : 2'd0;
      mem[slot*4]     = {$urandom_range(0, 32'h3fff_ffff), m};
      mem[slot*4 + 1] = $urandom;
      mem[slot*4 + 2] = $urandom;
      mem[slot*4 + 3] = 32'(nxt * 16);
    end
    return 32'(s * 16);
  endfunction

  // Memory read responder with random wait states
  initial forever begin
    @(negedge clk);
    rd_rdy  = rd_req && ($urandom_range(0, 2) != 0);
    rd_data = mem[rd_addr[7:2]];
    if (rd_req) seen_rd = 1'b1;
  end

  // Transfer engine model and output monitor
  initial forever begin
    @(negedge clk);
    if (busy) seen_busy = 1'b1;
    if (chan_done) n_done++;
    if (xfer_done) xfer_done = 1'b0;
    if (xfer_start) begin
      check(!prev_start, "R10 start width", 32'(prev_start), 0);
      if (n_start < exp_n) begin
        check(xfer_ctrl == exp_ctrl[n_start], "R5 ctrl", xfer_ctrl, exp_ctrl[n_start]);
        check(xfer_src == exp_src[n_start] && xfer_dst == exp_dst[n_start],
              "R5/R6 addresses", xfer_src, exp_src[n_start]);
      end else
        check(1'b0, "R7 extra launch", 32'(n_start), 32'(exp_n));
      n_start++;
      dly = $urandom_range(1, 4);
    end else if (dly > 0) begin
      dly--;
      if (dly == 0) xfer_done = 1'b1;
    end
    prev_start = xfer_start;
  end

  task automatic clear_counts();
    n_start = 0; n_done = 0; seen_rd = 0; seen_busy = 0;
  endtask

  // Trigger with a given config, optionally pulse trig while busy, await end
  task automatic run(input logic [31:0] ctrl, input logic [31:0] ptr,
                     input bit spam, input string tag);
    int cyc = 0;
    clear_counts();
    @(posedge clk); #1;
    cfg_ctrl = ctrl; cfg_next = ptr; cfg_src = $urandom; cfg_dst = $urandom;
    trig = 1'b1;
    @(posedge clk); #1;
    trig = 1'b0;
    while (n_done == 0 && cyc < 3000) begin
      @(posedge clk); #1;
      trig = spam && busy && ($urandom_range(0, 1) != 0);
      cyc++;
    end
    trig = 1'b0;
    repeat (6) @(posedge clk);
    #1;
    check(n_start == exp_n, {tag, " launches"}, 32'(n_start), 32'(exp_n));
    check(n_done == 1, {tag, " R8 single done"}, 32'(n_done), 1);
    check(!busy, {tag, " R9 idle after end"}, 32'(busy), 0);
  endtask

  initial begin
    n_tests = 0; n_fail = 0; dly = 0; exp_n = 0; prev_start = 0;
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 64; i++) mem[i] = '0;
    clear_counts();
    repeat (4) @(posedge clk);
    #1;
    check(!busy && !rd_req && !xfer_start && !chan_done, "R1 reset outputs",
          {28'd0, busy, rd_req, xfer_start, chan_done}, 0);
    rst = 1'b0;

    // R3: modes 0 and 3 do nothing
    for (int k = 0; k < 2; k++) begin
      clear_counts();
      @(posedge clk); #1;
      cfg_ctrl = (k == 0) ? 32'h0000_1200 : 32'h0000_1203; trig = 1'b1;
      @(posedge clk); #1; trig = 1'b0;
      repeat (20) @(posedge clk);
      #1;
      check(!seen_busy && n_start == 0 && n_done == 0 && !seen_rd, "R3 stop mode",
            32'(n_start + n_done), 0);
    end

    // R2: basic mode uses the config inputs, no read
    begin
      logic [31:0] c = 32'hABCD_0011;
      clear_counts();
      @(posedge clk); #1;
      cfg_ctrl = c; cfg_src = 32'h1111_2220; cfg_dst = 32'h3333_4440;
      exp_n = 1; exp_ctrl[0] = c; exp_src[0] = cfg_src; exp_dst[0] = cfg_dst;
      trig = 1'b1;
      @(posedge clk); #1; trig = 1'b0;
      check(xfer_start == 1'b1, "R2 launch next cycle", 32'(xfer_start), 1);
      repeat (12) @(posedge clk);
      #1;
      check(n_start == 1 && n_done == 1 && !seen_rd, "R2 basic single",
            32'(n_start), 1);
    end

    // R7: first descriptor is stop: no launch, one done
    begin
      logic [31:0] p = build(0, 1'b0);
      walk(p);
      run(32'h2, p, 1'b0, "R7 stop head");
    end
    // R6/R7: three-entry chain ended by stop entry
    begin
      logic [31:0] p = build(3, 1'b0);
      walk(p);
      run(32'h2, p, 1'b0, "R6 chain stop tail");
    end
    // R7: chain ended by a mode-1 entry, with trig spam (R9)
    begin
      logic [31:0] p = build(2, 1'b1);
      walk(p);
      run(32'h2, p, 1'b1, "R9 basic tail spam");
    end

    // Random chains
    for (int r = 0; r < 24; r++) begin
      bit eb = ($urandom_range(0, 1) != 0);
      int len = $urandom_range(eb ? 1 : 0, 4);
      logic [31:0] p = build(len, eb);
      walk(p);
      run({$urandom_range(0, 32'h3fff_ffff), 2'b10}, p,
          ($urandom_range(0, 1) != 0), "R4 random chain");
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=0", n_tests);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule